// File: doc/BRIEF.md
# Gapped Waveform Block Generator

This block turns a small preloaded sample memory into a framed test stream. Once enabled, it reads the memory in address order and sends the samples as blocks of a programmed length. An idle gap of a programmed number of cycles follows each block. Every block carries a block sequence number (BSN), and a sync flag marks the first sample of every Nth block. The stream appears on a valid/sop/eop/sync/bsn/data interface. The memory is loaded through its own write port. The memory depth is the next power of two at or above the default block length plus the default gap.

Settings are held in eight 32-bit write-only words. The generator either starts as soon as it is enabled, or it arms and waits for the next rising edge of a pulse-per-second input. Clearing enable lets the current block and its gap finish, and then the stream falls silent. Any setting written while blocks are flowing is picked up at the next block start, so a block in flight is never changed.

Control sits in a four-state machine:
- States: `ST_IDLE`, `ST_ARM`, `ST_DATA`, `ST_GAP`.
- Transitions out of `ST_IDLE`: to `ST_DATA` when enabled for an immediate start, or to `ST_ARM` when enabled with a PPS-aligned start.
- Transitions out of `ST_ARM`: to `ST_DATA` on a PPS rise, or back to `ST_IDLE` when enable is cleared.
- Transitions out of `ST_DATA` after the last sample: to `ST_GAP` when the gap is non-zero, to `ST_DATA` (the next block) when the gap is zero and enable is still set, or to `ST_IDLE` otherwise.
- Transitions out of `ST_GAP` when the gap runs out: to `ST_DATA` if enable is still set, otherwise to `ST_IDLE`.

One memory read stage separates the machine from the outputs. A matching delay on the framing keeps valid, data and markers aligned.

Top module: `wave_block_gen`

## Requirements
- R1: Reset state and register map.
  - During and after reset, all outputs are 0 and the generator is disabled.
  - Word addresses: 0 is control (bit 0 enable, bit 1 PPS-aligned start), 1 is samples per block, 2 is gap cycles, 3 is blocks per sync, 4 is the low address, 5 is the high address, 6 is initial BSN bits 31:0, and 7 is initial BSN bits 63:32.
  - Reset values: samples DEF_SPB, gap DEF_GAP, blocks per sync DEF_BPS, low address 0, high address DEF_SPB-1, initial BSN 0.
- R2: With bit 1 clear, a control write setting bit 0 that is sampled at clock edge E gives no valid after edge E+1. The first sample, with sop, is visible after edge E+2.
- R3: With bit 1 set, no output appears while waiting, even if PPS is held high. The first sop is visible one edge after the edge that first samples PPS high following a low sample.
- R4: Each block is exactly `samples` consecutive valid cycles, with sop on the first and eop on the last (both on a one-sample block). It is followed by exactly `gap` cycles with valid low. A gap of 0 gives back-to-back blocks. Samples per block must be at least 1.
- R5: Counting blocks from 0 at each start, block k has sync on its sop if and only if k mod blocks_per_sync is 0. A value of 0 or 1 marks every block. Sync never appears off sop.
- R6: The first block's BSN equals the initial BSN (truncated to BSN_W bits). Each later block's BSN is one more, wrapping modulo 2^BSN_W. The BSN is constant within a block.
- R7: Sample j of every block is the memory word at low + (j mod (high-low+1)). Reading restarts at low for each block. Requires low ≤ high.
- R8: After enable is cleared, the block in flight and its gap complete, and then valid stays low. No partial block is emitted. Re-enabling restarts at the initial BSN with sync on the first block.
- R9: A samples-per-block write landing during a block leaves that block's length unchanged. The new value applies from the next block start.
- R10: While valid is low, out_bsn and out_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps | input | 1 | Pulse-per-second, synchronous to clk |
| cfg_we | input | 1 | Settings word write strobe |
| cfg_addr | input | 3 | Settings word address |
| cfg_wdata | input | 32 | Settings write data |
| wav_we | input | 1 | Waveform memory write strobe |
| wav_addr | input | ADDR_W | Waveform memory write address |
| wav_wdata | input | DATA_W | Waveform memory write data |
| out_valid | output | 1 | Sample valid |
| out_sop | output | 1 | First sample of block |
| out_eop | output | 1 | Last sample of block |
| out_sync | output | 1 | Sync marker on selected block starts |
| out_bsn | output | BSN_W | Block sequence number |
| out_data | output | DATA_W | Sample data |

## Verification
The bench builds the block with 16-bit data, a 48-bit BSN, 5 samples, a 3-cycle gap and 4 blocks per sync as defaults. This gives an 8-word memory that a short loop fills with a computed pattern.

With a depth that small, the bench can sweep:
- every block length from 1 to 4;
- every gap from 0 to 2;
- every sync period from 0 to 3;
- a rotating low/high window, so address wrap inside a block is hit repeatedly.

The one-sample block with no gap shows the latest point at which a stop can still take effect. A BSN start near 2^48 shows the carry into the upper register word and the final wrap.

// File: rtl/wbg_pkg.sv
package wbg_pkg;
    localparam int REG_W = 32;
    localparam int REG_AW = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_DATA,
        ST_GAP
    } gen_state_e;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_SPB   = 3'd1,
        RA_GAP   = 3'd2,
        RA_BPS   = 3'd3,
        RA_LO    = 3'd4,
        RA_HI    = 3'd5,
        RA_BSN_L = 3'd6,
        RA_BSN_H = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic              run_en;
        logic              pps_start;
        logic [REG_W-1:0]  spb;
        logic [REG_W-1:0]  gap;
        logic [REG_W-1:0]  bps;
        logic [REG_W-1:0]  lo_addr;
        logic [REG_W-1:0]  hi_addr;
        logic [2*REG_W-1:0] bsn_init;
    } gen_cfg_t;
endpackage

// File: rtl/wbg_cfg_regs.sv
module wbg_cfg_regs
    import wbg_pkg::*;
#(
    parameter int DEF_SPB = 900,
    parameter int DEF_GAP = 100,
    parameter int DEF_BPS = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output gen_cfg_t          cfg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.run_en    <= 1'b0;
            cfg.pps_start <= 1'b0;
            cfg.spb       <= REG_W'(DEF_SPB);
            cfg.gap       <= REG_W'(DEF_GAP);
            cfg.bps       <= REG_W'(DEF_BPS);
            cfg.lo_addr   <= '0;
            cfg.hi_addr   <= REG_W'(DEF_SPB - 1);
            cfg.bsn_init  <= '0;
        end else if (we) begin
            unique case (addr)
                RA_CTRL: begin
                    cfg.run_en    <= wdata[0];
                    cfg.pps_start <= wdata[1];
                end
                RA_SPB:   cfg.spb                        <= wdata;
                RA_GAP:   cfg.gap                        <= wdata;
                RA_BPS:   cfg.bps                        <= wdata;
                RA_LO:    cfg.lo_addr                    <= wdata;
                RA_HI:    cfg.hi_addr                    <= wdata;
                RA_BSN_L: cfg.bsn_init[REG_W-1:0]        <= wdata;
                RA_BSN_H: cfg.bsn_init[2*REG_W-1:REG_W]  <= wdata;
                default:  cfg.run_en                     <= cfg.run_en;
            endcase
        end
    end
endmodule

// File: rtl/wbg_wave_mem.sv
module wbg_wave_mem #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem  [DEPTH];
    logic [DATA_W-1:0] pipe [RD_LAT];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        pipe[0] <= mem[rd_addr];
        for (int i = 1; i < RD_LAT; i++) begin
            pipe[i] <= pipe[i-1];
        end
    end

    assign rd_data = pipe[RD_LAT-1];
endmodule

// File: rtl/wbg_seq_fsm.sv
module wbg_seq_fsm
    import wbg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BSN_W  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gen_cfg_t          cfg,
    input  logic              pps,
    output logic              iss_valid,
    output logic              iss_sop,
    output logic              iss_eop,
    output logic              iss_sync,
    output logic [BSN_W-1:0]  iss_bsn,
    output logic [ADDR_W-1:0] rd_addr
);
    gen_state_e        state_q, state_d;
    logic              pps_q;
    logic              pps_rise;
    logic              start_gen, next_blk;
    logic              last_smp;
    logic [REG_W-1:0]  smp_q, gap_q, sync_q;
    logic [REG_W-1:0]  spb_a, gap_a, bps_a;
    logic [ADDR_W-1:0] lo_a, hi_a, addr_q;
    logic [BSN_W-1:0]  bsn_q;
    logic [REG_W:0]    sync_inc;
    logic              unused_bits;

    assign pps_rise    = pps & ~pps_q;
    assign last_smp    = (smp_q == spb_a - 1'b1);
    assign sync_inc    = {1'b0, sync_q} + 1'b1;
    assign unused_bits = ^{cfg.lo_addr, cfg.hi_addr, cfg.bsn_init, bps_a};

    // next state and block-start decisions
    always_comb begin
        state_d   = state_q;
        start_gen = 1'b0;
        next_blk  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg.run_en) begin
                    if (cfg.pps_start) begin
                        state_d = ST_ARM;
                    end else begin
                        state_d   = ST_DATA;
                        start_gen = 1'b1;
                    end
                end
            end
            ST_ARM: begin
                if (!cfg.run_en) begin
                    state_d = ST_IDLE;
                end else if (pps_rise) begin
                    state_d   = ST_DATA;
                    start_gen = 1'b1;
                end
            end
            ST_DATA: begin
                if (last_smp) begin
                    if (gap_a != '0) begin
                        state_d = ST_GAP;
                    end else if (cfg.run_en) begin
                        next_blk = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                if (gap_q == '0) begin
                    if (cfg.run_en) begin
                        state_d  = ST_DATA;
                        next_blk = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pps_q   <= 1'b0;
            smp_q   <= '0;
            gap_q   <= '0;
            sync_q  <= '0;
            spb_a   <= '0;
            gap_a   <= '0;
            bps_a   <= '0;
            lo_a    <= '0;
            hi_a    <= '0;
            addr_q  <= '0;
            bsn_q   <= '0;
        end else begin
            state_q <= state_d;
            pps_q   <= pps;
            if (start_gen || next_blk) begin
                spb_a  <= cfg.spb;
                gap_a  <= cfg.gap;
                bps_a  <= cfg.bps;
                lo_a   <= cfg.lo_addr[ADDR_W-1:0];
                hi_a   <= cfg.hi_addr[ADDR_W-1:0];
                addr_q <= cfg.lo_addr[ADDR_W-1:0];
                smp_q  <= '0;
                if (start_gen) begin
                    bsn_q  <= cfg.bsn_init[BSN_W-1:0];
                    sync_q <= '0;
                end else begin
                    bsn_q  <= bsn_q + 1'b1;
                    sync_q <= (sync_inc >= {1'b0, cfg.bps}) ? '0 : sync_inc[REG_W-1:0];
                end
            end else if (state_q == ST_DATA) begin
                smp_q  <= smp_q + 1'b1;
                addr_q <= (addr_q == hi_a) ? lo_a : addr_q + 1'b1;
                if (last_smp && gap_a != '0) begin
                    gap_q <= gap_a - 1'b1;
                end
            end else if (state_q == ST_GAP && gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    // issue-side outputs
    always_comb begin
        iss_valid = (state_q == ST_DATA);
        iss_sop   = iss_valid && (smp_q == '0);
        iss_eop   = iss_valid && last_smp;
        iss_sync  = iss_sop && (sync_q == '0);
        iss_bsn   = bsn_q;
        rd_addr   = addr_q;
    end

    assert_gap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (gap_q < gap_a));

    assert_bsn_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        next_blk |=> (bsn_q == $past(bsn_q) + 1'b1));

    assert_addr_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && lo_a <= hi_a) |-> (addr_q >= lo_a && addr_q <= hi_a));

    assert_arm_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && !pps_rise) |=> (state_q != ST_DATA));
endmodule

// File: rtl/wbg_out_align.sv
module wbg_out_align #(
    parameter int DATA_W = 32,
    parameter int BSN_W  = 48,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic              iss_sop,
    input  logic              iss_eop,
    input  logic              iss_sync,
    input  logic [BSN_W-1:0]  iss_bsn,
    input  logic [DATA_W-1:0] rd_data,
    output logic              o_valid,
    output logic              o_sop,
    output logic              o_eop,
    output logic              o_sync,
    output logic [BSN_W-1:0]  o_bsn,
    output logic [DATA_W-1:0] o_data
);
    localparam int FW = 4 + BSN_W;

    logic [FW-1:0]    stg [RD_LAT];
    logic [BSN_W-1:0] bsn_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RD_LAT; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= {iss_valid, iss_sop, iss_eop, iss_sync, iss_bsn};
            for (int i = 1; i < RD_LAT; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign {o_valid, o_sop, o_eop, o_sync, bsn_r} = stg[RD_LAT-1];
    assign o_bsn  = o_valid ? bsn_r : '0;
    assign o_data = o_valid ? rd_data : '0;

    assert_sop_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (o_sop || o_eop) |-> o_valid);

    assert_sync_on_sop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        o_sync |-> o_sop);

    assert_no_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_eop) |=> o_valid);

    assert_bsn_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_eop) |=> $stable(o_bsn));
endmodule

// File: rtl/wave_block_gen.sv
module wave_block_gen
    import wbg_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int BSN_W   = 48,
    parameter int DEF_SPB = 900,
    parameter int DEF_GAP = 100,
    parameter int DEF_BPS = 200000,
    parameter int RD_LAT  = 1,
    localparam int MEM_DEPTH = 1 << $clog2(DEF_SPB + DEF_GAP),
    localparam int ADDR_W    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pps,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              wav_we,
    input  logic [ADDR_W-1:0] wav_addr,
    input  logic [DATA_W-1:0] wav_wdata,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_sync,
    output logic [BSN_W-1:0]  out_bsn,
    output logic [DATA_W-1:0] out_data
);
    gen_cfg_t          cfg;
    logic              iss_valid, iss_sop, iss_eop, iss_sync;
    logic [BSN_W-1:0]  iss_bsn;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    wbg_cfg_regs #(
        .DEF_SPB (DEF_SPB),
        .DEF_GAP (DEF_GAP),
        .DEF_BPS (DEF_BPS)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    wbg_seq_fsm #(
        .ADDR_W (ADDR_W),
        .BSN_W  (BSN_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .pps       (pps),
        .iss_valid (iss_valid),
        .iss_sop   (iss_sop),
        .iss_eop   (iss_eop),
        .iss_sync  (iss_sync),
        .iss_bsn   (iss_bsn),
        .rd_addr   (rd_addr)
    );

    wbg_wave_mem #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .RD_LAT (RD_LAT)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wav_we),
        .wr_addr (wav_addr),
        .wr_data (wav_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    wbg_out_align #(
        .DATA_W (DATA_W),
        .BSN_W  (BSN_W),
        .RD_LAT (RD_LAT)
    ) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_sop   (iss_sop),
        .iss_eop   (iss_eop),
        .iss_sync  (iss_sync),
        .iss_bsn   (iss_bsn),
        .rd_data   (rd_data),
        .o_valid   (out_valid),
        .o_sop     (out_sop),
        .o_eop     (out_eop),
        .o_sync    (out_sync),
        .o_bsn     (out_bsn),
        .o_data    (out_data)
    );
endmodule

// File: tb/tb_wave_block_gen.sv
module tb_wave_block_gen;
    localparam int DW    = 16;
    localparam int BW    = 48;
    localparam int D_SPB = 5;
    localparam int D_GAP = 3;
    localparam int D_BPS = 4;
    localparam int AW    = $clog2(D_SPB + D_GAP);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = 4 + BW + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pps = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          wav_we = 1'b0;
    logic [AW-1:0] wav_addr = '0;
    logic [DW-1:0] wav_wdata = '0;
    logic          out_valid, out_sop, out_eop, out_sync;
    logic [BW-1:0] out_bsn;
    logic [DW-1:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [DW-1:0] ref_mem [DEPTH];

    always #10 clk = ~clk;

    wave_block_gen #(
        .DATA_W (DW), .BSN_W (BW), .DEF_SPB (D_SPB), .DEF_GAP (D_GAP), .DEF_BPS (D_BPS), .RD_LAT (1)
    ) dut (
        .clk (clk), .rst_n (rst_n), .pps (pps),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .wav_we (wav_we), .wav_addr (wav_addr), .wav_wdata (wav_wdata),
        .out_valid (out_valid), .out_sop (out_sop), .out_eop (out_eop),
        .out_sync (out_sync), .out_bsn (out_bsn), .out_data (out_data)
    );

    function automatic logic [PW-1:0] obs();
        return {out_valid, out_sop, out_eop, out_sync, out_bsn, out_data};
    endfunction

    task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_case(input int spb, input int gap, input int bps, input int lo, input int hi,
                            input logic [63:0] bsn0, input int nb, input bit use_pps,
                            input bit do_cfg, input int chg);
        int tail;
        int nbt;
        logic [PW-1:0] exp;
        if (do_cfg) begin
            reg_wr(3'd1, 32'(spb));
            reg_wr(3'd2, 32'(gap));
            reg_wr(3'd3, 32'(bps));
            reg_wr(3'd4, 32'(lo));
            reg_wr(3'd5, 32'(hi));
            reg_wr(3'd6, bsn0[31:0]);
            reg_wr(3'd7, bsn0[63:32]);
        end
        if (!use_pps) begin
            reg_wr(3'd0, 32'd1);
            @(negedge clk);
            chk("R2 no valid one edge after enable", obs(), '0);
            @(negedge clk);
        end else begin
            pps = 1'b1;
            reg_wr(3'd0, 32'd3);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk("R3 armed, PPS held high must not start", obs(), '0);
            end
            pps = 1'b0;
            @(negedge clk);
            chk("R3 armed, PPS low", obs(), '0);
            pps = 1'b1;
            @(negedge clk);
            chk("R3 no valid on PPS sampling edge", obs(), '0);
            pps = 1'b0;
            @(negedge clk);
        end
        tail = (chg != 0) ? chg : spb;
        nbt  = nb + ((tail + gap < 2) ? 1 : 0);
        for (int b = 0; b < nbt; b++) begin
            int cs;
            cs = (b == 0 || chg == 0) ? spb : chg;
            for (int c = 0; c < cs + gap; c++) begin
                if (c < cs) begin
                    exp = {1'b1, c == 0, c == cs - 1,
                           (c == 0) && ((bps <= 1) || (b % bps == 0)),
                           BW'(bsn0 + 64'(b)), ref_mem[lo + (c % (hi - lo + 1))]};
                end else begin
                    exp = '0;
                end
                if (chg != 0)
                    chk("R9 R4 R5 R6 R7 R10 stream with mid-block length write", obs(), exp);
                else
                    chk("R4 R5 R6 R7 R10 stream cycle", obs(), exp);
                if (b == nb - 2 && c == cs + gap - 1) begin
                    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'd0;
                end else if (chg != 0 && b == 0 && c == 0) begin
                    cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 32'(chg);
                end else begin
                    cfg_we = 1'b0;
                end
                @(negedge clk);
            end
        end
        cfg_we = 1'b0;
        for (int k = 0; k < spb + gap + 4; k++) begin
            chk("R8 silent after stop at block boundary", obs(), '0);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1 outputs zero in reset", obs(), '0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs zero after reset", obs(), '0);
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = DW'(i * 4951 + 165);
            wav_we = 1'b1; wav_addr = AW'(i); wav_wdata = ref_mem[i];
            @(negedge clk);
        end
        wav_we = 1'b0;
        @(negedge clk);
        chk("R1 disabled after memory load", obs(), '0);

        // R1: reset register values drive this run
        run_case(D_SPB, D_GAP, D_BPS, 0, D_SPB - 1, 64'd0, 6, 1'b0, 1'b0, 0);

        for (int s = 1; s <= 4; s++) begin
            for (int g = 0; g <= 2; g++) begin
                for (int p = 0; p <= 3; p++) begin
                    int lo;
                    int hi;
                    lo = (s + p) % 4;
                    hi = lo + ((s + g + p) % 4);
                    run_case(s, g, p, lo, hi, 64'h0000_0000_FFFF_FFFE + 64'(p), 5,
                             (g == 1) && (p >= 2), 1'b1, 0);
                end
            end
        end

        // R6: BSN wrap at 2^48
        run_case(3, 1, 2, 2, 6, 64'h0000_FFFF_FFFF_FFFF, 4, 1'b0, 1'b1, 0);
        // R9: length change lands mid-block
        run_case(4, 2, 2, 1, 6, 64'd100, 3, 1'b0, 1'b1, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 150000; k++) begin
            @(posedge clk);
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule